// File: doc/BRIEF.md
# Three-Channel Reloadable Timer with 40-bit Time Base

This peripheral sits on a simple 32-bit register bus and provides three independent down-counting timers plus one free-running 40-bit time-base counter. Each timer counts on one of two externally generated tick strobes, chosen per timer. It either reloads from its load register or wraps to all ones when it passes zero, and it raises a sticky level interrupt each time it does. Software acknowledges an interrupt by writing any value to that timer's clear register. To set a timer up, software writes the control register with the mode and clock choice while the enable bit is 0, then writes the load value, then writes control again with the enable bit set.

The time-base counter advances on its own tick strobe whenever its enable bit is set. It is read as a low 32-bit word and a high word. The high word carries the upper count bits and the enable flag. The prescalers that generate the tick strobes are outside the block.

Every register access is a single cycle with `bus_sel` high. A write takes effect at the clock edge that samples it. Read data is registered and appears on `bus_rdata` in the cycle after the read is presented. `bus_rdata` then holds that value until the next read.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset all three interrupts are low, every timer is disabled, all load, value and control registers read 0, and the time base reads 0 with its enable bit clear.
- R2: A write to a timer's load register (offset +0x0) stores the value and also copies it into that timer's current count, which is readable at offset +0x4.
- R3: An enabled timer decrements by one on each cycle in which its selected tick strobe is high. The strobe is `tick_fast` when control bit 3 is 1 and `tick_slow` when it is 0. A disabled timer, or a tick on the unselected strobe, leaves the count unchanged.
- R4: With control bit 6 set (periodic), a selected tick that finds the count at 0 reloads the count from the load register. A load value N therefore gives one interrupt every N+1 ticks.
- R5: With control bit 6 clear (free-running), a selected tick that finds the count at 0 sets the count to all ones.
- R6: The tick that finds the count at 0 sets the timer's interrupt output. The interrupt then stays high through further underflows until a write of any data to the clear register (offset +0xC) drops it. If an underflow and a clear write happen in the same cycle, the interrupt stays high.
- R7: The control register (offset +0x8) holds bit 7 (enable), bit 6 (periodic) and bit 3 (fast clock select). All other bits read back as 0.
- R8: The time base is a 40-bit counter. It is read at 0x60 (bits 31:0) and at 0x64, where bits 7:0 are count bits 39:32 and bit 8 is the enable. It increments on each cycle in which `tb_tick` is high and the enable is set. A write to 0x64 changes only the enable bit, and writes to 0x60 have no effect.
- R9: The timers sit at base offsets 0x00, 0x20 and 0x80, and each drives `irq[0]`, `irq[1]` and `irq[2]` respectively. An access to one timer never changes another timer.
- R10: A read returns its data one cycle later. Reads of unmapped offsets return 0, and `bus_rdata` holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_slow | input | 1 | Slow count strobe, one cycle per tick |
| tick_fast | input | 1 | Fast count strobe, one cycle per tick |
| tb_tick | input | 1 | Time-base count strobe |
| irq | output | 3 | Per-timer sticky interrupt |

## Verification
The assertions assume that the three tick strobes are single-cycle pulses sampled on the clock. They also assume that a clear register is decoded only when `bus_sel` and `bus_wr` are both high, so that an interrupt can fall only in a cycle that carries such a write and no competing tick. The bench drives every strobe and bus access as a one-cycle pulse between falling edges. It overlaps a tick with a clear write only in the one scenario that targets the same-cycle rule. It never reads a timer in a cycle where that timer also ticks.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int NUM_TIMERS = 3;
  localparam int BUS_W      = 32;

  localparam logic [7:0] OFS_LOAD  = 8'h00;
  localparam logic [7:0] OFS_VALUE = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h08;
  localparam logic [7:0] OFS_CLEAR = 8'h0C;
  localparam logic [7:0] TB_LO_ADDR = 8'h60;
  localparam logic [7:0] TB_HI_ADDR = 8'h64;

  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_PER_BIT  = 6;
  localparam int CTRL_FAST_BIT = 3;
  localparam int TB_EN_BIT     = 8;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast;
  } tmr_ctrl_t;

  function automatic logic [7:0] tmr_base(input int idx);
    case (idx)
      0:       tmr_base = 8'h00;
      1:       tmr_base = 8'h20;
      default: tmr_base = 8'h80;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_to_word(input tmr_ctrl_t c);
    logic [BUS_W-1:0] w;
    w = '0;
    w[CTRL_EN_BIT]   = c.en;
    w[CTRL_PER_BIT]  = c.periodic;
    w[CTRL_FAST_BIT] = c.fast;
    return w;
  endfunction
endpackage

// File: rtl/tick_bus_decode.sv
module tick_bus_decode
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NT     = NUM_TIMERS
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NT-1:0]     load_we,
  output logic [NT-1:0]     ctrl_we,
  output logic [NT-1:0]     clr_we,
  output logic              tb_hi_we,
  output logic              rd_en
);
  logic wr_cyc;
  assign wr_cyc = bus_sel && bus_wr;
  assign rd_en  = bus_sel && !bus_wr;

  for (genvar g = 0; g < NT; g++) begin : g_dec
    localparam logic [7:0] BASE = tmr_base(g);
    assign load_we[g] = wr_cyc && (bus_addr == ADDR_W'(BASE + OFS_LOAD));
    assign ctrl_we[g] = wr_cyc && (bus_addr == ADDR_W'(BASE + OFS_CTRL));
    assign clr_we[g]  = wr_cyc && (bus_addr == ADDR_W'(BASE + OFS_CLEAR));
  end

  assign tb_hi_we = wr_cyc && (bus_addr == ADDR_W'(TB_HI_ADDR));
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             load_we,
  input  logic             ctrl_we,
  input  logic             clr_we,
  input  logic [CNT_W-1:0] load_in,
  input  tmr_ctrl_t        ctrl_in,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] count_q,
  output tmr_ctrl_t        ctrl_q,
  output logic             irq_q
);
  logic step;
  logic at_zero;
  logic underflow;

  assign step      = ctrl_q.en && (ctrl_q.fast ? tick_fast : tick_slow);
  assign at_zero   = (count_q == '0);
  assign underflow = step && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= '0;
      count_q <= '0;
      ctrl_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_in;

      if (load_we) begin
        load_q  <= load_in;
        count_q <= load_in;
      end else if (step) begin
        if (at_zero) count_q <= ctrl_q.periodic ? load_q : '1;
        else         count_q <= count_q - 1'b1;
      end

      if (underflow)   irq_q <= 1'b1;
      else if (clr_we) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase #(
  parameter int TB_W = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tb_tick,
  input  logic            en_we,
  input  logic            en_in,
  output logic            en_q,
  output logic [TB_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      count_q <= '0;
    end else begin
      if (en_we) en_q <= en_in;
      if (en_q && tb_tick) count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int TB_W   = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              tb_tick,
  output logic [NUM_TIMERS-1:0] irq
);
  localparam int NT = NUM_TIMERS;

  logic [NT-1:0] load_we, ctrl_we, clr_we;
  logic          tb_hi_we, rd_en;

  logic [CNT_W-1:0] load_w  [NT];
  logic [CNT_W-1:0] count_w [NT];
  tmr_ctrl_t        ctrl_w  [NT];
  tmr_ctrl_t        ctrl_in;

  logic            tb_en_w;
  logic [TB_W-1:0] tb_count_w;
  logic [BUS_W-1:0] rd_mux;

  tick_bus_decode #(.ADDR_W(ADDR_W), .NT(NT)) dec_i (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .load_we  (load_we),
    .ctrl_we  (ctrl_we),
    .clr_we   (clr_we),
    .tb_hi_we (tb_hi_we),
    .rd_en    (rd_en)
  );

  assign ctrl_in.en       = bus_wdata[CTRL_EN_BIT];
  assign ctrl_in.periodic = bus_wdata[CTRL_PER_BIT];
  assign ctrl_in.fast     = bus_wdata[CTRL_FAST_BIT];

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    tick_down_counter #(.CNT_W(CNT_W)) tmr_i (
      .clk       (clk),
      .rst       (rst),
      .tick_slow (tick_slow),
      .tick_fast (tick_fast),
      .load_we   (load_we[g]),
      .ctrl_we   (ctrl_we[g]),
      .clr_we    (clr_we[g]),
      .load_in   (bus_wdata[CNT_W-1:0]),
      .ctrl_in   (ctrl_in),
      .load_q    (load_w[g]),
      .count_q   (count_w[g]),
      .ctrl_q    (ctrl_w[g]),
      .irq_q     (irq[g])
    );
  end

  tick_timebase #(.TB_W(TB_W)) tb_i (
    .clk     (clk),
    .rst     (rst),
    .tb_tick (tb_tick),
    .en_we   (tb_hi_we),
    .en_in   (bus_wdata[TB_EN_BIT]),
    .en_q    (tb_en_w),
    .count_q (tb_count_w)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NT; i++) begin
      if (bus_addr == ADDR_W'(tmr_base(i) + OFS_LOAD))  rd_mux = BUS_W'(load_w[i]);
      if (bus_addr == ADDR_W'(tmr_base(i) + OFS_VALUE)) rd_mux = BUS_W'(count_w[i]);
      if (bus_addr == ADDR_W'(tmr_base(i) + OFS_CTRL))  rd_mux = ctrl_to_word(ctrl_w[i]);
    end
    if (bus_addr == ADDR_W'(TB_LO_ADDR)) rd_mux = tb_count_w[31:0];
    if (bus_addr == ADDR_W'(TB_HI_ADDR)) begin
      rd_mux = BUS_W'(tb_count_w >> 32);
      rd_mux[TB_EN_BIT] = tb_en_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TB_W   = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              tick_slow,
  input logic              tick_fast,
  input logic              tb_tick,
  input logic [NUM_TIMERS-1:0] irq,
  input logic              tb_en,
  input logic [TB_W-1:0]   tb_count
);
  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_irq
    localparam logic [7:0] CLR = tmr_base(g) + OFS_CLEAR;

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (irq[g] && !(bus_sel && bus_wr && bus_addr == ADDR_W'(CLR))) |=> irq[g]);

    // R6
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(CLR) && !tick_slow && !tick_fast) |=> !irq[g]);
  end

  // R3
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_slow && !tick_fast && !(bus_sel && bus_wr)) |=> $stable(irq));

  // R8
  tb_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tb_tick |=> $stable(tb_count));

  // R8
  tb_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tb_tick && tb_en) |=> (tb_count == $past(tb_count) + 1'b1));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind tick_timer_unit tick_timer_chk #(.ADDR_W(ADDR_W), .TB_W(TB_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .tick_slow (tick_slow),
  .tick_fast (tick_fast),
  .tb_tick   (tb_tick),
  .irq       (irq),
  .tb_en     (tb_en_w),
  .tb_count  (tb_count_w)
);

// File: tb/tick_timer_unit_tb.sv
module tick_timer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic        tb_tick = 1'b0;
  logic [2:0]  irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tick_timer_unit dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_slow(tick_slow), .tick_fast(tick_fast), .tb_tick(tb_tick), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic pulse(input int which, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (which == 0) tick_slow = 1'b1;
      else if (which == 1) tick_fast = 1'b1;
      else tb_tick = 1'b1;
      @(negedge clk);
      tick_slow = 1'b0; tick_fast = 1'b0; tb_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    check("R1 irq", {29'd0, irq}, 32'd0);
    rd_check("R1 ctrl0", 8'h08, 32'd0);
    rd_check("R1 value2", 8'h84, 32'd0);
    rd_check("R1 tb_lo", 8'h60, 32'd0);
    rd_check("R1 tb_hi", 8'h64, 32'd0);
  endtask

  task automatic t_ctrl_load;
    wr(8'h08, 32'hFFFF_FFFF);
    rd_check("R7 ctrl all ones", 8'h08, 32'h0000_00C8);
    wr(8'h08, 32'h48);
    rd_check("R7 ctrl mode", 8'h08, 32'h48);
    wr(8'h00, 32'd5);
    rd_check("R2 load", 8'h00, 32'd5);
    rd_check("R2 value copy", 8'h04, 32'd5);
  endtask

  task automatic t_count;
    pulse(1, 3);
    rd_check("R3 disabled", 8'h04, 32'd5);
    wr(8'h08, 32'hC8);
    pulse(0, 2);
    rd_check("R3 unselected tick", 8'h04, 32'd5);
    pulse(1, 2);
    rd_check("R3 decrement", 8'h04, 32'd3);
  endtask

  task automatic t_periodic;
    pulse(1, 3);
    rd_check("R4 at zero", 8'h04, 32'd0);
    check("R4 no irq yet", {29'd0, irq}, 32'd0);
    pulse(1, 1);
    check("R4 irq after N+1", {29'd0, irq}, 32'd1);
    rd_check("R4 reload", 8'h04, 32'd5);
  endtask

  task automatic t_irq;
    pulse(1, 6);
    check("R6 sticky", {29'd0, irq}, 32'd1);
    rd_check("R6 second reload", 8'h04, 32'd5);
    wr(8'h0C, 32'h1234);
    check("R6 clear", {29'd0, irq}, 32'd0);
    wr(8'h00, 32'd0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = '0; tick_fast = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_fast = 1'b0;
    check("R6 underflow beats clear", {29'd0, irq}, 32'd1);
    wr(8'h0C, 32'd0);
    check("R6 clear again", {29'd0, irq}, 32'd0);
    wr(8'h08, 32'h48);
  endtask

  task automatic t_freerun;
    wr(8'h28, 32'h08);
    wr(8'h20, 32'd1);
    wr(8'h28, 32'h88);
    pulse(1, 1);
    check("R5 no irq at one", {29'd0, irq}, 32'd0);
    pulse(1, 1);
    check("R9 irq1 only", {29'd0, irq}, 32'd2);
    rd_check("R5 wrap all ones", 8'h24, 32'hFFFF_FFFF);
    rd_check("R9 timer0 untouched", 8'h04, 32'd0);
  endtask

  task automatic t_timer3;
    wr(8'h88, 32'h40);
    wr(8'h80, 32'd7);
    wr(8'h88, 32'hC0);
    pulse(1, 4);
    rd_check("R9 timer3 slow held", 8'h84, 32'd7);
    rd_check("R9 timer2 moved", 8'h24, 32'hFFFF_FFFB);
    pulse(0, 7);
    check("R4 timer3 no irq", {29'd0, irq}, 32'd2);
    pulse(0, 1);
    check("R4 timer3 irq", {29'd0, irq}, 32'd6);
    rd_check("R4 timer3 reload", 8'h84, 32'd7);
  endtask

  task automatic t_timebase;
    pulse(2, 3);
    rd_check("R8 disabled", 8'h60, 32'd0);
    wr(8'h64, 32'h1FF);
    rd_check("R8 hi enable only", 8'h64, 32'h100);
    wr(8'h60, 32'hABCD);
    pulse(2, 5);
    rd_check("R8 low count", 8'h60, 32'd5);
    wr(8'h64, 32'h0);
    pulse(2, 2);
    rd_check("R8 stopped", 8'h60, 32'd5);
    rd_check("R8 hi off", 8'h64, 32'd0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd_check("R10 unmapped 0x40", 8'h40, 32'd0);
    rd_check("R10 unmapped 0x10", 8'h10, 32'd0);
    rd(8'h80, d);
    repeat (3) @(negedge clk);
    check("R10 hold", bus_rdata, 32'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_ctrl_load;
    t_count;
    t_periodic;
    t_irq;
    t_freerun;
    t_timer3;
    t_timebase;
    t_unmapped;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule